// File: doc/BRIEF.md
# Microcoded Register-Move Datapath Without Arithmetic

This block carries out one byte-wide micro-instruction on every clock over three byte registers: a high pointer, a low pointer and a transfer byte. It has no arithmetic unit. It only moves bytes between those registers and an external memory, and it forms each memory address by ORing a few instruction bits into the pointer pair. The high pointer's top bit is sent to the microcode sequencer as the only condition flag. The transfer byte and the low pointer are also exported, because the sequencer uses them as jump targets.

The decode is purely combinational. A micro-instruction presented before a rising edge drives the address bus, the active-low read or write strobe and the outgoing data in the same cycle. Any register it loads takes its new value at that rising edge. The decoder sorts each code into one of six named classes: LOAD_B, LOAD_L, STORE_B, LOAD_H, JUMP and IDLE. There is no hidden sequencing, so no class depends on the one before it. The sequencer, the microcode store and the external memory decoding sit outside the block.

Top module: `udp_datapath`

## Requirements
- R1: While rst_n is low, both strobes are high. After reset the transfer byte, the high pointer and the low pointer are all 0x00, so seq_b, seq_l and flag read 0.
- R2: When instruction bit 4 is 0, the address is {H | (bit3<<7), L | bits[2:0]}. H is the high byte, bit 3 is ORed onto address bit 15 and bits 2..0 are ORed onto address bits 2..0, by bitwise OR and never by addition.
- R3: When instruction bit 4 is 1, the pointer pair is disabled. The address is then {bit3, 12 zero bits, bits[2:0]}, which reaches only 0x0000–0x0007 or 0x8000–0x8007.
- R4: Codes 0x00–0x1F (LOAD_B) drive rd_n low, and the transfer byte takes din at the rising edge.
- R5: Codes 0x20–0x3F (LOAD_L) drive rd_n low, and the low pointer takes din at the rising edge.
- R6: Codes 0x80–0x9F (STORE_B) drive wr_n low and dout_en high, and dout carries the transfer byte.
- R7: Codes 0xC8–0xCF and 0xD8–0xDF (LOAD_H) load the high pointer with the low address byte, which is L|nn or nn alone. In the same cycle they drive wr_n low with that byte on dout, and address bit 15 is 1.
- R8: Codes 0xC0–0xC7 and 0xD0–0xD7 are H loads with bit 3 clear. They assert no strobe and leave the high pointer unchanged.
- R9: Jump codes 0xA0–0xBF and undefined codes 0x40–0x7F and 0xE0–0xFF assert no strobe and change no register.
- R10: rd_n and wr_n are never low together, and dout_en is high exactly when wr_n is low.
- R11: flag equals bit 7 of the high pointer, seq_b equals the transfer byte and seq_l equals the low pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop | input | 8 | Current micro-instruction |
| din | input | 8 | Data bus into the block |
| addr | output | 16 | External address bus |
| dout | output | 8 | Data bus out of the block |
| dout_en | output | 1 | High when dout should drive the bus |
| rd_n | output | 1 | Active-low memory read strobe |
| wr_n | output | 1 | Active-low memory write strobe |
| flag | output | 1 | Condition flag, bit 7 of the high pointer |
| seq_b | output | 8 | Transfer byte, for sequencer jumps |
| seq_l | output | 8 | Low pointer, for sequencer jumps |

## Verification
The address, the strobes, dout and dout_en all follow the current uop and the register contents with zero cycles of delay. The bench therefore drives uop and din on the falling edge and compares those outputs 2 ns later, well before the next rising edge. Register results (seq_b, seq_l, flag) are due one cycle after the micro-instruction that loads them. They are compared 1 ns after that rising edge, against a behavioural model that updates at the same edge. Directed sequences cover each class, OR addressing against non-zero pointers, and the guarded H codes. A long run of arbitrary codes follows, with the full comparison made on every cycle.

// File: rtl/udp_pkg.sv
package udp_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;

    typedef enum logic [2:0] {
        CLS_LOAD_B,
        CLS_LOAD_L,
        CLS_STORE_B,
        CLS_LOAD_H,
        CLS_JUMP,
        CLS_IDLE
    } op_class_e;

    typedef struct packed {
        op_class_e          cls;
        logic               direct;   // pointer pair disabled
        logic               hi_or;    // OR term for top address bit
        logic [OFS_W-1:0]   lo_or;    // OR term for low address bits
    } udp_dec_t;
endpackage

// File: rtl/udp_decode.sv
module udp_decode
    import udp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] uop,
    output udp_dec_t     dec
);
    always_comb begin
        dec.direct = uop[4];
        dec.hi_or  = uop[3];
        dec.lo_or  = uop[OFS_W-1:0];
        unique case (uop[7:5])
            3'b000:  dec.cls = CLS_LOAD_B;
            3'b001:  dec.cls = CLS_LOAD_L;
            3'b100:  dec.cls = CLS_STORE_B;
            3'b101:  dec.cls = CLS_JUMP;
            3'b110:  dec.cls = uop[3] ? CLS_LOAD_H : CLS_IDLE;
            default: dec.cls = CLS_IDLE;
        endcase
    end
endmodule

// File: rtl/udp_addr_gen.sv
module udp_addr_gen
    import udp_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int AW = 2 * W
) (
    input  logic [W-1:0]  hreg,
    input  logic [W-1:0]  lreg,
    input  udp_dec_t      dec,
    output logic [AW-1:0] addr
);
    logic [W-1:0] hi_base, lo_base;
    logic [W-1:0] hi_ofs, lo_ofs;

    always_comb begin
        hi_base = dec.direct ? '0 : hreg;
        lo_base = dec.direct ? '0 : lreg;
        hi_ofs  = '0;
        hi_ofs[W-1] = dec.hi_or;
        lo_ofs  = '0;
        lo_ofs[OFS_W-1:0] = dec.lo_or;
        addr = {hi_base | hi_ofs, lo_base | lo_ofs};
    end
endmodule

// File: rtl/udp_regfile.sv
module udp_regfile
    import udp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_b,
    input  logic         we_l,
    input  logic         we_h,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] h_in,
    output logic [W-1:0] b_q,
    output logic [W-1:0] l_q,
    output logic [W-1:0] h_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
            l_q <= '0;
            h_q <= '0;
        end else begin
            if (we_b) b_q <= bus_in;
            if (we_l) l_q <= bus_in;
            if (we_h) h_q <= h_in;
        end
    end
endmodule

// File: rtl/udp_datapath.sv
module udp_datapath
    import udp_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int AW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  uop,
    input  logic [W-1:0]  din,
    output logic [AW-1:0] addr,
    output logic [W-1:0]  dout,
    output logic          dout_en,
    output logic          rd_n,
    output logic          wr_n,
    output logic          flag,
    output logic [W-1:0]  seq_b,
    output logic [W-1:0]  seq_l
);
    udp_dec_t     dec;
    logic [W-1:0] b_q, l_q, h_q;
    logic         do_rd, do_wr;
    logic         we_b, we_l, we_h;

    udp_decode #(.W(W)) u_dec (.uop(uop), .dec(dec));

    udp_addr_gen #(.W(W)) u_agen (
        .hreg(h_q), .lreg(l_q), .dec(dec), .addr(addr)
    );

    // output process: strobes and write enables per class
    always_comb begin
        do_rd = 1'b0;
        do_wr = 1'b0;
        we_b  = 1'b0;
        we_l  = 1'b0;
        we_h  = 1'b0;
        dout  = b_q;
        unique case (dec.cls)
            CLS_LOAD_B:  begin do_rd = 1'b1; we_b = 1'b1; end
            CLS_LOAD_L:  begin do_rd = 1'b1; we_l = 1'b1; end
            CLS_STORE_B: begin do_wr = 1'b1; end
            CLS_LOAD_H:  begin do_wr = 1'b1; we_h = 1'b1; dout = addr[W-1:0]; end
            CLS_JUMP:    ;
            CLS_IDLE:    ;
            default:     ;
        endcase
    end

    udp_regfile #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_b(we_b), .we_l(we_l), .we_h(we_h),
        .bus_in(din), .h_in(addr[W-1:0]),
        .b_q(b_q), .l_q(l_q), .h_q(h_q)
    );

    assign rd_n    = ~(rst_n & do_rd);
    assign wr_n    = ~(rst_n & do_wr);
    assign dout_en = ~wr_n;
    assign flag    = h_q[W-1];
    assign seq_b   = b_q;
    assign seq_l   = l_q;
endmodule

// File: rtl/udp_datapath_chk.sv
module udp_datapath_chk #(
    parameter int W = 8,
    localparam int AW = 2 * W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  uop,
    input logic [W-1:0]  din,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  dout,
    input logic          dout_en,
    input logic          rd_n,
    input logic          wr_n,
    input logic          flag,
    input logic [W-1:0]  seq_b,
    input logic [W-1:0]  seq_l
);
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (rd_n && wr_n));

    p_direct_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uop[4] |-> (addr[AW-2:3] == '0));

    p_load_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop[7:5] == 3'b000) |=> (seq_b == $past(din)));

    p_load_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uop[7:5] == 3'b001) |=> (seq_l == $past(din)));

    p_store_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uop[7:5] == 3'b100) |-> (!wr_n && dout_en && dout == seq_b));

    p_h_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && uop[7:6] == 2'b11) |-> addr[AW-1]);

    p_h_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop[7:5] == 3'b110 && uop[3]) |=> (flag == $past(addr[W-1])));

    p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop[7:5] == 3'b110 && !uop[3]) |-> (rd_n && wr_n));

    p_jump_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uop[7:5] == 3'b101) |=> ($stable(seq_b) && $stable(seq_l) && $stable(flag)));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en == !wr_n);
endmodule

bind udp_datapath udp_datapath_chk #(.W(W)) u_chk (.*);

// File: tb/sim_udp_datapath.sv
`timescale 1ns/1ps
module sim_udp_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  uop = 8'h00;
    logic [7:0]  din = 8'h00;
    logic [15:0] addr;
    logic [7:0]  dout, seq_b, seq_l;
    logic        dout_en, rd_n, wr_n, flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [7:0] mb = 0, mh = 0, ml = 0;

    always #4 clk = ~clk;

    udp_datapath u0 (
        .clk(clk), .rst_n(rst_n), .uop(uop), .din(din), .addr(addr),
        .dout(dout), .dout_en(dout_en), .rd_n(rd_n), .wr_n(wr_n),
        .flag(flag), .seq_b(seq_b), .seq_l(seq_l)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s uop=%h actual=%h expected=%h at %0t", req, uop, act, exp, $time);
        end
    endtask

    // one micro-instruction, compared on both sides of the edge
    task automatic step(input logic [7:0] u, input logic [7:0] d);
        logic [7:0] ehi, elo;
        bit is_ldb, is_ldl, is_st, is_ldh;
        @(negedge clk);
        uop = u;
        din = d;
        is_ldb = (u < 8'h20);
        is_ldl = (u >= 8'h20 && u < 8'h40);
        is_st  = (u >= 8'h80 && u < 8'hA0);
        is_ldh = (u >= 8'hC0 && u < 8'hE0 && u[3]);
        ehi = u[4] ? 8'h00 : mh;
        elo = u[4] ? 8'h00 : ml;
        if (u[3]) ehi = ehi | 8'h80;
        elo = elo | {5'b0, u[2:0]};
        #2;
        chk(addr == {ehi, elo}, u[4] ? "R3 addr" : "R2 addr", addr, {ehi, elo});
        chk(rd_n == !(is_ldb || is_ldl), is_ldl ? "R5 rd_n" : (is_ldb ? "R4 rd_n" : "R9 rd_n"), rd_n, !(is_ldb || is_ldl));
        chk(wr_n == !(is_st || is_ldh), is_ldh ? "R7 wr_n" : (is_st ? "R6 wr_n" : "R8 R9 wr_n"), wr_n, !(is_st || is_ldh));
        chk(!(rd_n == 0 && wr_n == 0) && dout_en == !wr_n, "R10 strobes", {rd_n, wr_n, dout_en}, 0);
        if (is_st) chk(dout == mb, "R6 dout", dout, mb);
        if (is_ldh) chk(dout == elo && addr[15], "R7 dout", dout, elo);
        @(posedge clk);
        if (is_ldb) mb = d;
        if (is_ldl) ml = d;
        if (is_ldh) mh = elo;
        #1;
        chk(seq_b == mb, is_ldb ? "R4 seq_b" : "R11 seq_b", seq_b, mb);
        chk(seq_l == ml, is_ldl ? "R5 seq_l" : "R11 seq_l", seq_l, ml);
        chk(flag == mh[7], is_ldh ? "R7 flag" : "R11 flag", flag, mh[7]);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with a store and a load presented
        uop = 8'h80;
        #3;
        chk(rd_n && wr_n, "R1 strobes in reset", {rd_n, wr_n}, 2'b11);
        uop = 8'h00;
        #10;
        chk(rd_n && wr_n, "R1 strobes in reset", {rd_n, wr_n}, 2'b11);
        chk(seq_b == 0 && seq_l == 0 && flag == 0, "R1 registers", {seq_b, seq_l}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed: loads, stores, OR addressing
        step(8'h00, 8'h5A);   // R4 B from HL
        step(8'h25, 8'h31);   // R5 L from HL|5
        step(8'h1B, 8'hC3);   // R4 B direct 0x8003
        step(8'h82, 8'h00);   // R6 store B to HL|2
        step(8'h97, 8'h00);   // R6 store direct 0x0007
        step(8'hCC, 8'h00);   // R7 H <= L|4 = 0x35
        step(8'h0E, 8'h77);   // R2 addr {0xB5, 0x37}
        step(8'hD9, 8'h00);   // R7 H <= 1
        step(8'hCF, 8'h00);   // R7 H <= L|7
        step(8'h3A, 8'hFF);   // R5 L direct
        step(8'hCA, 8'h00);   // R7 H <= 0xFF, flag 1
        step(8'hC4, 8'h00);   // R8 guarded
        step(8'hD2, 8'h00);   // R8 guarded
        step(8'hA3, 8'h11);   // R9 jump
        step(8'hB0, 8'h22);   // R9 jump
        step(8'h55, 8'h33);   // R9 undefined
        step(8'hF8, 8'h44);   // R9 undefined
        step(8'h98, 8'h00);   // R6 store direct 0x8000

        // arbitrary codes
        for (int i = 0; i < 600; i++) begin
            step(8'($urandom), 8'($urandom));
        end

        // R1 again: mid-run reset clears the registers
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk(seq_b == 0 && seq_l == 0 && flag == 0, "R1 mid-run reset", {seq_b, seq_l}, 0);
        chk(rd_n && wr_n, "R1 strobes in reset", {rd_n, wr_n}, 2'b11);
        mb = 0; mh = 0; ml = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(8'hDF, 8'h00);   // R7 H <= 7
        step(8'h10, 8'h9C);   // R4 direct 0x0000

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule